// File: doc/BRIEF.md
# Weighted Round-Robin Target Selector

This block picks a destination for each incoming allocation request. A bitmask selects which of the targets are eligible. A programmable weight per target says how many grants that target receives in a row before the selector moves on. The selector moves through eligible targets in ascending index order and wraps from the highest eligible index back to the lowest. When every weight is one, the result is a plain one-to-one rotation.

Each target has an "unavailable" input. A request that finds the current target unavailable goes to the next available eligible target, counting upwards from the current one and wrapping around. The skipped target keeps its remaining credit, and the selector makes no later correction for the imbalance this causes. Clearing the mask stops all grants and raises an error flag.

Top module: `wrr_target_sel`

## Requirements
- R1: A grant only ever names a target whose mask bit was set in the cycle the request was accepted.
- R2: The current target receives consecutive grants until its credit is used up. The selector then moves to the next set mask bit above it, wrapping to the lowest. With weights 2 and 1 on targets 0 and 1, the order is 0, 0, 1 repeating.
- R3: Over a full rotation, grant counts match the weights. With mask bits 0, 2 and 5 set and weights 4, 7 and 9, forty grants split 8, 14 and 18.
- R4: With all weights equal to 1, grants alternate strictly among the masked targets (0, 1, 0, 1 for mask 0b11).
- R5: If the current target is unavailable, the grant goes to the next target above it that is both in the mask and available, wrapping around. The current target's credit and position stay unchanged. If no masked target is available, `req_rdy` is low and no grant is issued.
- R6: After reset, and in any cycle where the mask differs from the previous cycle, selection restarts at the lowest set mask bit with a credit equal to that target's weight.
- R7: The weight of target i is the 8-bit field at bits [8i+7:8i] of `weights`. A value of 0 acts as 1.
- R8: A request is accepted when `req` and `req_rdy` are both high. Each accepted request produces exactly one `gnt_vld` pulse carrying `gnt_id`, in the following cycle. No grant appears without an accepted request.
- R9: With an all-zero mask, `err` is high, `req_rdy` is low and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| elig_mask | input | N_TGT | Eligible targets, bit i for target i |
| weights | input | N_TGT*WT_W | Per-target weight fields, target i at [WT_W*i +: WT_W] |
| unavail | input | N_TGT | Target i cannot take a grant this cycle |
| req | input | 1 | Allocation request |
| req_rdy | output | 1 | A masked, available target exists |
| gnt_vld | output | 1 | One-cycle grant pulse |
| gnt_id | output | ID_W | Granted target index |
| err | output | 1 | Mask is empty |

## Verification
A corrupted pointer or credit shows at the ports on the very next grant. The granted index departs from the sequence predicted from the weights, or a run of grants to one target is one too long or one too short. A fault in the fallback shows as a grant to an unavailable target, or as a shifted rotation after the skipped target becomes free again, within two grants. A missed restart shows on the first grant after a mask change, because that grant does not go to the lowest set bit.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;

    // Where the grant of an accepted request comes from
    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_CURRENT  = 2'd1,
        SRC_FALLBACK = 2'd2
    } gnt_src_e;

    localparam int WT_FLOOR = 1;

    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wrr_scan.sv
`timescale 1ns/1ps
// Finds the first set bit strictly after 'start', wrapping; 'start' is tested last.
module wrr_scan #(
    parameter int N    = 8,
    parameter int ID_W = 3
) (
    input  logic [N-1:0]    vec,
    input  logic [ID_W-1:0] start,
    output logic            found,
    output logic [ID_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = start;
        // Descending so the nearest offset is written last and wins
        for (int k = N; k >= 1; k--) begin
            int p;
            p = int'(start) + k;
            if (p >= N) p = p - N;
            if (vec[p]) begin
                found = 1'b1;
                idx   = ID_W'(p);
            end
        end
    end
endmodule

// File: rtl/wrr_weight_mux.sv
`timescale 1ns/1ps
module wrr_weight_mux
    import wrr_pkg::*;
#(
    parameter int N    = 8,
    parameter int WT_W = 8,
    parameter int ID_W = 3
) (
    input  logic [N*WT_W-1:0] weights,
    input  logic [ID_W-1:0]   sel,
    output logic [WT_W-1:0]   wt_eff
);
    logic [WT_W-1:0] raw;

    always_comb begin
        raw    = weights[int'(sel)*WT_W +: WT_W];
        wt_eff = (raw == '0) ? WT_W'(WT_FLOOR) : raw;
    end
endmodule

// File: rtl/wrr_target_sel.sv
`timescale 1ns/1ps
module wrr_target_sel
    import wrr_pkg::*;
#(
    parameter int N_TGT = 8,
    parameter int WT_W  = 8,
    localparam int ID_W = id_width(N_TGT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_TGT-1:0]      elig_mask,
    input  logic [N_TGT*WT_W-1:0] weights,
    input  logic [N_TGT-1:0]      unavail,
    input  logic                  req,
    output logic                  req_rdy,
    output logic                  gnt_vld,
    output logic [ID_W-1:0]       gnt_id,
    output logic                  err
);
    localparam logic [ID_W-1:0] TOP_IDX = ID_W'(N_TGT - 1);

    // Registered selection state
    logic [ID_W-1:0]  ptr_q;
    logic [WT_W-1:0]  cred_q;
    logic [N_TGT-1:0] mask_q;
    logic             first_q;

    logic             restart;
    logic             lo_found, nxt_found, fb_found;
    logic [ID_W-1:0]  lo_idx, nxt_idx, fb_idx;
    logic [WT_W-1:0]  lo_wt, nxt_wt;
    logic [ID_W-1:0]  cur_ptr, ptr_d, gnt_id_d;
    logic [WT_W-1:0]  cur_cred, cred_d;
    logic [N_TGT-1:0] avail;
    logic             accept;
    gnt_src_e         src;

    assign restart = first_q | (elig_mask != mask_q);
    assign avail   = elig_mask & ~unavail;

    // Lowest set mask bit: scan starting after the top index
    wrr_scan #(.N(N_TGT), .ID_W(ID_W)) u_scan_lo (
        .vec(elig_mask), .start(TOP_IDX), .found(lo_found), .idx(lo_idx)
    );
    wrr_weight_mux #(.N(N_TGT), .WT_W(WT_W), .ID_W(ID_W)) u_wt_lo (
        .weights(weights), .sel(lo_idx), .wt_eff(lo_wt)
    );

    assign cur_ptr  = restart ? lo_idx : ptr_q;
    assign cur_cred = restart ? lo_wt  : cred_q;

    // Next eligible target once the credit runs out
    wrr_scan #(.N(N_TGT), .ID_W(ID_W)) u_scan_nxt (
        .vec(elig_mask), .start(cur_ptr), .found(nxt_found), .idx(nxt_idx)
    );
    wrr_weight_mux #(.N(N_TGT), .WT_W(WT_W), .ID_W(ID_W)) u_wt_nxt (
        .weights(weights), .sel(nxt_idx), .wt_eff(nxt_wt)
    );

    // Fallback target when the current one is unavailable
    wrr_scan #(.N(N_TGT), .ID_W(ID_W)) u_scan_fb (
        .vec(avail), .start(cur_ptr), .found(fb_found), .idx(fb_idx)
    );

    assign err     = ~lo_found;
    assign req_rdy = |avail;
    assign accept  = req & req_rdy;

    always_comb begin
        if (!accept)             src = SRC_NONE;
        else if (avail[cur_ptr]) src = SRC_CURRENT;
        else                     src = SRC_FALLBACK;
    end

    always_comb begin
        ptr_d    = cur_ptr;
        cred_d   = cur_cred;
        gnt_id_d = cur_ptr;
        case (src)
            SRC_CURRENT: begin
                if (cur_cred <= WT_W'(1)) begin
                    ptr_d  = nxt_idx;
                    cred_d = nxt_wt;
                end else begin
                    cred_d = cur_cred - WT_W'(1);
                end
            end
            SRC_FALLBACK: gnt_id_d = fb_idx;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            cred_q  <= WT_W'(WT_FLOOR);
            mask_q  <= '0;
            first_q <= 1'b1;
            gnt_vld <= 1'b0;
            gnt_id  <= '0;
        end else begin
            ptr_q   <= ptr_d;
            cred_q  <= cred_d;
            mask_q  <= elig_mask;
            first_q <= 1'b0;
            gnt_vld <= accept;
            gnt_id  <= gnt_id_d;
        end
    end

    AST_GNT_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> mask_q[gnt_id]); // R1
    AST_ACCEPT_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (req && req_rdy) |=> gnt_vld); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !(req && req_rdy) |=> !gnt_vld); // R8
    AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        err |-> !req_rdy); // R9
    AST_CREDIT_LIVE: assert property (@(posedge clk) disable iff (rst)
        !first_q |-> (cred_q != '0)); // R7
    AST_NEXT_EXISTS: assert property (@(posedge clk) disable iff (rst)
        !err |-> nxt_found); // R2
    AST_FALLBACK_FOUND: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FALLBACK) |-> fb_found); // R5

endmodule

// File: tb/wrr_target_sel_tb.sv
`timescale 1ns/1ps
module wrr_target_sel_tb;
    localparam int N = 8;
    localparam int WW = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic [N-1:0]  mask, busy;
    logic [N*WW-1:0] wbus;
    logic          req;
    logic          req_rdy, gnt_vld, err;
    logic [IW-1:0] gnt_id;

    wrr_target_sel #(.N_TGT(N), .WT_W(WW)) u_dut (
        .clk(clk), .rst(rst), .elig_mask(mask), .weights(wbus),
        .unavail(busy), .req(req), .req_rdy(req_rdy),
        .gnt_vld(gnt_vld), .gnt_id(gnt_id), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_q[$];
    int log_q[$];

    // Reference model state
    int m_ptr, m_cred;
    logic [N-1:0] m_prev;
    bit m_first;

    task automatic check(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic int weff(input int i);
        int w;
        w = int'(wbus[i*WW +: WW]);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int after(input logic [N-1:0] v, input int p);
        for (int k = 1; k <= N; k++) begin
            if (v[(p + k) % N]) return (p + k) % N;
        end
        return p;
    endfunction

    function automatic void set_w(input int i, input int w);
        wbus[i*WW +: WW] = WW'(w);
    endfunction

    // Driver: one cycle of stimulus plus the model's prediction
    task automatic step(input bit rq, input logic [N-1:0] bz, input logic [N-1:0] mk);
        bit rdy;
        int id;
        @(negedge clk);
        req = rq; busy = bz; mask = mk;
        if (m_first || mk != m_prev) begin
            m_ptr  = after(mk, N - 1);
            m_cred = weff(m_ptr);
        end
        m_prev = mk; m_first = 1'b0;
        rdy = |(mk & ~bz);
        #1;
        check(req_rdy === rdy, "R5 req_rdy", int'(req_rdy), int'(rdy));
        check(err === (mk == '0), "R9 err", int'(err), int'(mk == '0));
        if (rq && rdy) begin
            if (!bz[m_ptr]) begin
                id = m_ptr;
                m_cred--;
                if (m_cred == 0) begin
                    m_ptr  = after(mk, m_ptr);
                    m_cred = weff(m_ptr);
                end
            end else begin
                id = after(mk & ~bz, m_ptr);
            end
            exp_q.push_back(id);
        end
    endtask

    // Monitor: pops predictions as grants appear
    always @(negedge clk) begin
        if (!rst && gnt_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 grant without request", int'(gnt_id), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(gnt_id) == e, "R2 scoreboard grant id", int'(gnt_id), e);
            end
            log_q.push_back(int'(gnt_id));
        end
    end

    task automatic flush(input logic [N-1:0] mk);
        step(1'b0, '0, mk);
        step(1'b0, '0, mk);
    endtask

    task automatic expect_log(input int e[$], input string r);
        check(log_q.size() == e.size(), r, log_q.size(), e.size());
        for (int i = 0; i < e.size() && i < log_q.size(); i++)
            check(log_q[i] == e[i], r, log_q[i], e[i]);
        log_q.delete();
    endtask

    // Mask to zero for a cycle so new weights take effect on the restart
    task automatic new_test;
        step(1'b0, '0, '0);
        wbus = '0;
        for (int i = 0; i < N; i++) set_w(i, 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt[N];
        rst = 1'b1; req = 1'b0; busy = '0; mask = 8'b0000_0011; wbus = '0;
        for (int i = 0; i < N; i++) set_w(i, 1);
        m_first = 1'b1; m_prev = '0; m_ptr = 0; m_cred = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(gnt_vld === 1'b0, "R8 reset gnt_vld", int'(gnt_vld), 0);
        check(err === 1'b0, "R9 reset err", int'(err), 0);
        check(req_rdy === 1'b1, "R9 reset req_rdy", int'(req_rdy), 1);

        // R4: unit weights alternate
        for (int i = 0; i < 6; i++) step(1'b1, '0, 8'b11);
        flush(8'b11);
        expect_log('{0, 1, 0, 1, 0, 1}, "R4 alternation");

        // R2: weights 2 and 1
        new_test(); set_w(0, 2); set_w(1, 1);
        for (int i = 0; i < 6; i++) step(1'b1, '0, 8'b11);
        flush(8'b11);
        expect_log('{0, 0, 1, 0, 0, 1}, "R2 weighted order");

        // R7: zero weights behave as one
        new_test(); set_w(0, 0); set_w(1, 0);
        for (int i = 0; i < 4; i++) step(1'b1, '0, 8'b11);
        flush(8'b11);
        expect_log('{0, 1, 0, 1}, "R7 zero weight");

        // R3: 4:7:9 on targets 0, 2, 5
        new_test(); set_w(0, 4); set_w(2, 7); set_w(5, 9);
        for (int i = 0; i < 40; i++) step(1'b1, '0, 8'b0010_0101);
        flush(8'b0010_0101);
        for (int i = 0; i < N; i++) cnt[i] = 0;
        foreach (log_q[i]) cnt[log_q[i]]++;
        check(cnt[0] == 8, "R3 count target 0", cnt[0], 8);
        check(cnt[2] == 14, "R3 count target 2", cnt[2], 14);
        check(cnt[5] == 18, "R3 count target 5", cnt[5], 18);
        check(cnt[0] + cnt[2] + cnt[5] == 40, "R1 only masked targets", cnt[0] + cnt[2] + cnt[5], 40);
        check(log_q[3] == 0 && log_q[4] == 2, "R2 run boundary", log_q[4], 2);
        log_q.delete();

        // R5: fallback keeps the skipped credit
        new_test(); set_w(0, 2); set_w(1, 1);
        step(1'b1, '0, 8'b11);
        step(1'b1, 8'b01, 8'b11);
        step(1'b1, '0, 8'b11);
        step(1'b1, '0, 8'b11);
        flush(8'b11);
        expect_log('{0, 1, 0, 1}, "R5 fallback credit");

        // R5: fallback wraps around
        new_test();
        step(1'b1, '0, 8'b1010);
        step(1'b1, 8'b1000, 8'b1010);
        step(1'b1, '0, 8'b1010);
        flush(8'b1010);
        expect_log('{1, 1, 3}, "R5 fallback wrap");

        // R5/R8: every masked target unavailable
        step(1'b1, 8'b1010, 8'b1010);
        flush(8'b1010);
        expect_log('{}, "R5 all unavailable");

        // R9: empty mask
        step(1'b1, '0, '0);
        check(req_rdy === 1'b0, "R9 empty req_rdy", int'(req_rdy), 0);
        flush('0);
        expect_log('{}, "R9 empty no grant");

        // R6: mask change restarts at the lowest set bit
        new_test(); set_w(0, 3); set_w(1, 1); set_w(2, 2);
        step(1'b1, '0, 8'b011);
        step(1'b1, '0, 8'b110);
        step(1'b1, '0, 8'b110);
        step(1'b1, '0, 8'b110);
        step(1'b1, '0, 8'b110);
        flush(8'b110);
        expect_log('{0, 1, 2, 2, 1}, "R6 restart");

        check(exp_q.size() == 0, "R8 outstanding grants", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule